// File: doc/BRIEF.md
# Write Leveling Calibration Engine

This block tunes the output strobe delay of every byte lane of a DDR3 interface at start-up. Each lane needs its own delay setting because the clock reaches each memory device at a different time on a fly-by route. All lanes are searched together. In each trial the engine raises one leveling pulse and then waits a programmable number of settle cycles. It then samples each lane's feedback bit on three consecutive cycles and takes a majority vote. Every lane that is still searching then moves its delay code up by one step.

A lane stops searching at the first code where its vote is 1 and the vote of the previous trial was 0. The engine holds that code on the lane's slice of the delay output, which drives the dynamic delay input of the lane's strobe and data output path. A lane that reaches the top code without finding that edge is flagged as failed. When every lane has either locked or failed, the engine raises done. The codes then stay fixed until a new start request or a reset.

Calibration starts by itself when reset is released. A start request after done clears all codes and flags and runs the search again.

Top module: `wlvl_engine`

## Requirements
- R1: While rst_n is low, pulse_o, done_o, every fail_o bit and every delay code are 0.
- R2: With AUTO_START=1, the first leveling pulse appears in the first cycle after the first rising clock edge that sees rst_n high, with no start request.
- R3: Delay codes are 0 when a calibration begins, and a lane's code only changes by +1 (one step per trial) until the next start.
- R4: pulse_o is high for exactly one cycle per trial. fb_i is sampled at the end of the 3 cycles that follow the pulse cycle plus settle_i wait cycles. Consecutive pulses are settle_i+6 cycles apart. settle_i is captured when calibration starts.
- R5: Each lane's decision for a trial is the majority of its three samples, so a 1 in only the middle sample does not count as a 1.
- R6: A lane locks at the first code whose vote is 1 after a trial whose vote was 0, and holds that code. A 1 on the very first trial does not lock.
- R7: A lane that evaluates code 127 (all ones) without locking sets its fail_o bit and keeps code 127.
- R8: Lanes are searched in parallel on a shared pulse. done_o rises only once every lane has locked or failed, so a run takes as many trials as its slowest lane.
- R9: A start request while calibration is running is ignored: it changes neither the trial count nor the result.
- R10: A start request while idle or done clears all codes, fail bits and done_o on the next cycle and runs calibration again.
- R11: Once done_o is high, the codes, fail bits and done_o stay fixed whatever fb_i does, until the next start or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run calibration again |
| settle_i | input | WAIT_W | Wait cycles between the pulse and the first sample |
| fb_i | input | NUM_LANES | Clock level returned by the memory on each lane |
| pulse_o | output | 1 | Leveling strobe pulse request, one cycle per trial |
| dly_code_o | output | NUM_LANES*CODE_W | Per-lane dynamic delay codes; lane i at bits [i*CODE_W +: CODE_W] |
| fail_o | output | NUM_LANES | Per-lane flag: no edge found before the top code |
| done_o | output | 1 | Every lane has locked or failed |

## Verification
The hardest case to reach from the ports is a noisy sample that falls exactly in the middle of a trial's three-sample window, just before a lane's true edge. The bench counts cycles from each observed pulse and uses the known settle value to place a one-cycle inverted feedback level on the middle sample edge of every trial. It then checks that each lane still locks at its true threshold. Two other cases are hard to reach. A start request is injected after a chosen number of pulses, and the bench checks that the trial count is unchanged. After done, the feedback model is changed completely, and the bench checks that the held codes do not move.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_SAMP,
    ST_EVAL,
    ST_NEXT,
    ST_DONE
  } seq_state_t;

  // two-of-three decision over the per-trial samples
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // edge found: a previous trial exists, it voted 0, this one votes 1
  function automatic logic edge_found(input logic first_trial,
                                      input logic prev_vote,
                                      input logic cur_vote);
    return !first_trial && !prev_vote && cur_vote;
  endfunction

endpackage

// File: rtl/wlvl_seq.sv
module wlvl_seq
  import wlvl_pkg::*;
#(
  parameter int WAIT_W     = 8,
  parameter bit AUTO_START = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] settle_i,
  input  logic              all_fin,
  output logic              pulse,
  output logic              sample_en,
  output logic              eval_en,
  output logic              restart,
  output logic              done
);

  localparam int SAMPLES = 3;
  localparam int SCNT_W  = $clog2(SAMPLES);

  seq_state_t        state_q, state_d;
  logic              boot_q;
  logic [WAIT_W-1:0] settle_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [SCNT_W-1:0] scnt_q;
  logic              wait_last;
  logic              samp_last;

  assign restart   = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && (start_i || boot_q);
  assign wait_last = ({1'b0, wcnt_q} + 1'b1) == {1'b0, settle_q};
  assign samp_last = scnt_q == SCNT_W'(SAMPLES - 1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (restart) state_d = ST_PULSE;
      ST_PULSE: state_d = (settle_q == '0) ? ST_SAMP : ST_WAIT;
      ST_WAIT:  if (wait_last) state_d = ST_SAMP;
      ST_SAMP:  if (samp_last) state_d = ST_EVAL;
      ST_EVAL:  state_d = ST_NEXT;
      ST_NEXT:  state_d = all_fin ? ST_DONE : ST_PULSE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      boot_q   <= AUTO_START;
      settle_q <= '0;
      wcnt_q   <= '0;
      scnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (restart) begin
        boot_q   <= 1'b0;
        settle_q <= settle_i;
      end
      if (state_q == ST_WAIT) wcnt_q <= wcnt_q + 1'b1;
      else                    wcnt_q <= '0;
      if (state_q == ST_SAMP) scnt_q <= scnt_q + 1'b1;
      else                    scnt_q <= '0;
    end
  end

  assign pulse     = state_q == ST_PULSE;
  assign sample_en = state_q == ST_SAMP;
  assign eval_en   = state_q == ST_EVAL;
  assign done      = state_q == ST_DONE;

endmodule

// File: rtl/wlvl_lane.sv
module wlvl_lane
  import wlvl_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              sample_en,
  input  logic              eval_en,
  input  logic              fb,
  output logic [CODE_W-1:0] code,
  output logic              locked,
  output logic              failed
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q;
  logic [2:0]        samp_q;
  logic              prev_q;
  logic              first_q;
  logic              lock_q;
  logic              fail_q;
  logic              vote;
  logic              searching;

  assign vote      = vote3(samp_q);
  assign searching = !lock_q && !fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      code_q  <= '0;
      samp_q  <= '0;
      prev_q  <= 1'b0;
      first_q <= 1'b1;
      lock_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      if (sample_en) samp_q <= {samp_q[1:0], fb};
      if (eval_en && searching) begin
        first_q <= 1'b0;
        prev_q  <= vote;
        if (edge_found(first_q, prev_q, vote)) lock_q <= 1'b1;
        else if (code_q == CODE_MAX)           fail_q <= 1'b1;
        else                                   code_q <= code_q + 1'b1;
      end
    end
  end

  assign code   = code_q;
  assign locked = lock_q;
  assign failed = fail_q;

endmodule

// File: rtl/wlvl_engine.sv
module wlvl_engine #(
  parameter int NUM_LANES  = 4,
  parameter int CODE_W     = 7,
  parameter int WAIT_W     = 8,
  parameter bit AUTO_START = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [WAIT_W-1:0]           settle_i,
  input  logic [NUM_LANES-1:0]        fb_i,
  output logic                        pulse_o,
  output logic [NUM_LANES*CODE_W-1:0] dly_code_o,
  output logic [NUM_LANES-1:0]        fail_o,
  output logic                        done_o
);

  logic                 restart;
  logic                 sample_en;
  logic                 eval_en;
  logic                 all_fin;
  logic [NUM_LANES-1:0] lane_lock;
  logic [NUM_LANES-1:0] lane_fail;

  assign all_fin = &(lane_lock | lane_fail);

  wlvl_seq #(
    .WAIT_W    (WAIT_W),
    .AUTO_START(AUTO_START)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .settle_i (settle_i),
    .all_fin  (all_fin),
    .pulse    (pulse_o),
    .sample_en(sample_en),
    .eval_en  (eval_en),
    .restart  (restart),
    .done     (done_o)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    wlvl_lane #(
      .CODE_W(CODE_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .sample_en(sample_en),
      .eval_en  (eval_en),
      .fb       (fb_i[g]),
      .code     (dly_code_o[g*CODE_W +: CODE_W]),
      .locked   (lane_lock[g]),
      .failed   (lane_fail[g])
    );
  end

  assign fail_o = lane_fail;

endmodule

// File: rtl/wlvl_engine_chk.sv
module wlvl_engine_chk #(
  parameter int NUM_LANES = 4,
  parameter int CODE_W    = 7
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        pulse_o,
  input logic                        done_o,
  input logic [NUM_LANES-1:0]        fail_o,
  input logic [NUM_LANES*CODE_W-1:0] dly_code_o,
  input logic                        restart,
  input logic [NUM_LANES-1:0]        lane_lock
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o); // R4

  AST_DONE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((lane_lock | fail_o) == {NUM_LANES{1'b1}})); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (dly_code_o == '0 && fail_o == '0 && !done_o)); // R10

  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !restart) |=> ($stable(dly_code_o) && $stable(fail_o))); // R11

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !done_o) |=>
        (dly_code_o[g*CODE_W +: CODE_W] == $past(dly_code_o[g*CODE_W +: CODE_W]) ||
         dly_code_o[g*CODE_W +: CODE_W] == $past(dly_code_o[g*CODE_W +: CODE_W]) + 1'b1)); // R3

    AST_FAIL_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_o[g]) |-> (dly_code_o[g*CODE_W +: CODE_W] == CODE_MAX)); // R7

    AST_LOCK_XOR_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      !(lane_lock[g] && fail_o[g])); // R6
  end

endmodule

bind wlvl_engine wlvl_engine_chk #(
  .NUM_LANES(NUM_LANES),
  .CODE_W   (CODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pulse_o   (pulse_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .dly_code_o(dly_code_o),
  .restart   (restart),
  .lane_lock (lane_lock)
);

// File: tb/tb_wlvl_engine.sv
`timescale 1ns/100ps
module tb_wlvl_engine;

  localparam int NL = 4;
  localparam int CW = 7;
  localparam int WW = 8;
  localparam int CMAX = (1 << CW) - 1;

  typedef struct {
    int    code [NL];
    bit    fl   [NL];
    int    pulses;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [WW-1:0]     settle_i = '0;
  logic [NL-1:0]     fb_i;
  logic              pulse_o;
  logic [NL*CW-1:0]  dly_code_o;
  logic [NL-1:0]     fail_o;
  logic              done_o;

  int   total = 0;
  int   bad = 0;
  int   thr [NL];
  logic [NL-1:0] gmask = '0;
  int   cur_w = 0;
  int   cyc_from_pulse = 1000;
  int   cyc = 0;
  int   last_pulse = -1;
  int   pcount = 0;
  bit   pulse_prev = 1'b0;
  bit   done_prev = 1'b0;
  bit   run_done = 1'b0;
  int   prev_code [NL];
  exp_t q [$];

  always #2.5 clk = ~clk;

  wlvl_engine #(.NUM_LANES(NL), .CODE_W(CW), .WAIT_W(WW), .AUTO_START(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i), .fb_i(fb_i),
    .pulse_o(pulse_o), .dly_code_o(dly_code_o), .fail_o(fail_o), .done_o(done_o)
  );

  function automatic int code_of(input int i);
    return int'(dly_code_o[i*CW +: CW]);
  endfunction

  // memory model: feedback is 1 once the lane delay reaches its threshold;
  // optional one-cycle inversion on the middle sample of each trial
  always_comb begin
    for (int i = 0; i < NL; i++)
      fb_i[i] = (code_of(i) >= thr[i]) ^ (gmask[i] && (cyc_from_pulse == cur_w + 2));
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: timing, step size, and scoreboard compare at done
  always @(negedge clk) begin
    cyc++;
    if (pulse_o) cyc_from_pulse = 0; else cyc_from_pulse++;
    if (rst_n) begin
      if (pulse_o) begin
        chk(!pulse_prev, "R4 pulse width", 2, 1);
        if (!pulse_prev) begin
          pcount++;
          if (last_pulse >= 0) chk(cyc - last_pulse == cur_w + 6, "R4 trial period", cyc - last_pulse, cur_w + 6);
          last_pulse = cyc;
        end
      end
      for (int i = 0; i < NL; i++) begin
        if (code_of(i) != prev_code[i] && code_of(i) != 0)
          chk(code_of(i) == prev_code[i] + 1, "R3 step", code_of(i), prev_code[i] + 1);
      end
      if (done_o && !done_prev) begin
        if (q.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          for (int i = 0; i < NL; i++) begin
            chk(code_of(i) == e.code[i], e.fl[i] ? "R7 code" : "R6 code", code_of(i), e.code[i]);
            chk(fail_o[i] == e.fl[i], "R7 fail flag", int'(fail_o[i]), int'(e.fl[i]));
          end
          chk(pcount == e.pulses, e.tag, pcount, e.pulses);
        end
        run_done = 1'b1;
      end
    end
    for (int i = 0; i < NL; i++) prev_code[i] = code_of(i);
    pulse_prev = pulse_o;
    done_prev  = done_o;
  end

  // driver: compute expectation from thresholds and push it
  task automatic prep_run(input int t0, input int t1, input int t2, input int t3,
                          input int w, input logic [NL-1:0] gm, input string tag);
    exp_t e;
    int   tt [NL];
    tt[0] = t0; tt[1] = t1; tt[2] = t2; tt[3] = t3;
    e.pulses = 0;
    for (int i = 0; i < NL; i++) begin
      int n;
      if (tt[i] >= 1 && tt[i] <= CMAX) begin e.code[i] = tt[i]; e.fl[i] = 1'b0; n = tt[i] + 1; end
      else begin e.code[i] = CMAX; e.fl[i] = 1'b1; n = CMAX + 1; end
      if (n > e.pulses) e.pulses = n;
      thr[i] = tt[i];
    end
    e.tag = tag;
    q.push_back(e);
    gmask = gm;
    cur_w = w;
    settle_i = WW'(w);
    pcount = 0;
    last_pulse = -1;
    run_done = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(dly_code_o == '0 && fail_o == '0 && !done_o, "R10 clear on start", int'(dly_code_o != '0), 0);
  endtask

  task automatic wait_done(input int mid);
    int n = 0;
    bit sent = 1'b0;
    while (!run_done && n < 5000) begin
      @(negedge clk);
      n++;
      if (mid > 0 && !sent && pcount == mid) begin
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        sent = 1'b1;
      end
    end
    if (!run_done) chk(1'b0, "watchdog run", n, 0);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin thr[i] = 1000; prev_code[i] = 0; end
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!pulse_o, "R1 pulse in reset", int'(pulse_o), 0);
    chk(!done_o, "R1 done in reset", int'(done_o), 0);
    chk(fail_o == '0, "R1 fail in reset", int'(fail_o), 0);
    chk(dly_code_o == '0, "R1 codes in reset", int'(dly_code_o != '0), 0);
    // R2: automatic first run after reset release
    prep_run(3, 10, 1, 20, 2, '0, "R8 trial count");
    rst_n = 1'b1;
    @(negedge clk);
    chk(pulse_o, "R2 auto start pulse", int'(pulse_o), 1);
    wait_done(0);
    // R7: failing lanes, lock at top code, no settle wait
    prep_run(0, 200, 7, 127, 0, '0, "R7 trial count");
    kick();
    wait_done(0);
    // R5: middle-sample glitch on every lane
    prep_run(6, 4, 9, 2, 3, 4'hF, "R5 trial count");
    kick();
    wait_done(0);
    // R9: start while running is ignored
    prep_run(15, 5, 5, 5, 1, '0, "R9 trial count");
    kick();
    wait_done(5);
    // R11: hold after done while feedback changes
    begin
      logic [NL*CW-1:0] held;
      logic [NL-1:0]    hf;
      held = dly_code_o;
      hf = fail_o;
      for (int i = 0; i < NL; i++) thr[i] = 0;
      gmask = 4'hF;
      repeat (40) @(negedge clk);
      chk(dly_code_o == held, "R11 codes held", int'(dly_code_o != held), 0);
      chk(fail_o == hf && done_o, "R11 flags held", int'(done_o), 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule